// File: doc/BRIEF.md
# Two-Cycle Time-Shared Signed Multiplier

This block forms the exact signed product of a 17-bit multiplicand and a 14-bit multiplier. It does not build a full 17x14 array. It keeps one 17x8 signed array and uses that array twice. The 14-bit operand is cut into two 7-bit halves. In the first busy cycle the array multiplies the multiplicand by the lower half, which is widened with a zero on top so that it always counts as a non-negative value. In the second busy cycle the array multiplies the multiplicand by the upper half, which is widened with a copy of its own sign bit. The second partial product is moved up by seven bit positions and added to the first, which gives a 31-bit two's-complement result.

The caller holds `start` high for a cycle while presenting both operands. The block captures them only when it is idle. One cycle later the lower-half multiply runs, and the upper-half multiply follows in the next cycle. After that, `done` goes high for a single cycle and `product` carries the new result. The result register keeps that value until the next operation completes.

Top module: `smul_ts_top`

## Requirements
- R1: When `done` is high, `product` read as a 31-bit two's-complement value equals the exact signed product of the captured 17-bit `a_in` and 14-bit `b_in`. This holds for every operand value, including -65536, -8192, zero and the largest positive values.
- R2: Bits 6..0 of the multiplier always carry positive weight. A multiplier with bit 6 set, such as 64 or 127, gives the same product as an ordinary integer multiply.
- R3: The operands are captured at the rising edge where `start` is high and the block is idle. Later changes on `a_in` and `b_in` do not affect the result of that operation.
- R4: When `start` is accepted at edge E0, `done` is low after edge E1, high for exactly one cycle after edge E2, and low again after edge E3.
- R5: A `start` seen while an operation is in progress (after E0, at E1 and E2) is ignored. It produces no extra `done` pulse and leaves the result of the running operation unchanged.
- R6: A synchronous active-high `rst` returns the block to idle, drives `done` low and clears `product` to zero on the next edge, including when it arrives in the middle of an operation.
- R7: `product` keeps its value in every cycle except the one that follows the upper-half multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiply; taken only when idle |
| a_in | input | 17 | Signed multiplicand (two's complement) |
| b_in | input | 14 | Signed multiplier (two's complement) |
| done | output | 1 | One-cycle pulse marking a fresh result |
| product | output | 31 | Signed product (two's complement) |

## Verification
The embedded properties assume three things. The lower-half cycle is always followed by the upper-half cycle. A `start` is sampled only in the idle state. The operand registers are never rewritten while the block is busy. The stimulus respects these assumptions by never asserting `rst` while the arithmetic checks run, and by raising `start` during busy cycles only in the dedicated R5 sequence. Each operand set stays inside its 17-bit or 14-bit range, so every expected product fits in 31 bits and can be compared exactly with the integer multiply that the bench computes.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // Default operand widths for the time-shared multiplier
    parameter int unsigned SMUL_A_W = 17;
    parameter int unsigned SMUL_B_W = 14;

    // Sequencing phases: idle, lower-half multiply, upper-half multiply
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } phase_e;

    // Widen a chunk by one bit: zero on top for the unsigned lower half,
    // sign copy for the signed upper half (7-bit chunks by default).
    function automatic logic [7:0] widen_chunk7(input logic [6:0] c, input logic is_hi);
        return {is_hi & c[6], c};
    endfunction

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   load,
    output logic   done
);

    phase_e phase_q;
    logic   done_q;

    assign load  = start && (phase_q == PH_IDLE);
    assign phase = phase_q;
    assign done  = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_HI);
            case (phase_q)
                PH_IDLE: if (start) phase_q <= PH_LO;
                PH_LO:   phase_q <= PH_HI;
                PH_HI:   phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R4
    lo_then_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LO) |=> (phase_q == PH_HI));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R5
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (phase_q != PH_IDLE)) |=> (phase_q != PH_LO));

endmodule

// File: rtl/smul_slice.sv
module smul_slice #(
    parameter int unsigned A_W  = 17,
    parameter int unsigned C_W  = 7,
    localparam int unsigned PP_W = A_W + C_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [A_W-1:0]  a,
    input  logic        [C_W-1:0]  chunk,
    input  logic                   hi_sel,
    output logic signed [PP_W-1:0] pp
);

    logic signed [C_W:0] ext;

    // Per-cycle signedness: only the upper chunk may be negative
    assign ext = $signed({hi_sel & chunk[C_W-1], chunk});
    assign pp  = PP_W'(a) * PP_W'(ext);

    // R2
    lo_chunk_positive_chk: assert property (@(posedge clk) disable iff (rst)
        (!hi_sel && (chunk != '0) && (a != '0)) |-> (pp[PP_W-1] == a[A_W-1]));

    // R1
    hi_chunk_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_sel && chunk[C_W-1] && !a[A_W-1] && (a != '0)) |-> pp[PP_W-1]);

endmodule

// File: rtl/smul_accum.sv
module smul_accum
    import smul_pkg::*;
#(
    parameter int unsigned PP_W = 25,
    parameter int unsigned P_W  = 31,
    parameter int unsigned SH   = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  phase_e                 phase,
    input  logic signed [PP_W-1:0] pp,
    output logic        [P_W-1:0]  prod
);

    logic signed [P_W-1:0] pp_ext;
    logic signed [P_W-1:0] lo_q;
    logic signed [P_W-1:0] prod_q;

    assign pp_ext = {{(P_W-PP_W){pp[PP_W-1]}}, pp};
    assign prod   = prod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            prod_q <= '0;
        end else begin
            if (phase == PH_LO) lo_q <= pp_ext;
            if (phase == PH_HI) prod_q <= lo_q + (pp_ext <<< SH);
        end
    end

    // R7
    prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_HI) |=> $stable(prod_q));

endmodule

// File: rtl/smul_ts_top.sv
module smul_ts_top
    import smul_pkg::*;
#(
    parameter int unsigned A_W = SMUL_A_W,
    parameter int unsigned B_W = SMUL_B_W,
    localparam int unsigned C_W  = B_W / 2,
    localparam int unsigned PP_W = A_W + C_W + 1,
    localparam int unsigned P_W  = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           done,
    output logic [P_W-1:0] product
);

    phase_e                 phase;
    logic                   load;
    logic signed [A_W-1:0]  a_q;
    logic        [B_W-1:0]  b_q;
    logic        [C_W-1:0]  chunk;
    logic                   hi_sel;
    logic signed [PP_W-1:0] pp;

    smul_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .load  (load),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    assign hi_sel = (phase == PH_HI);
    assign chunk  = hi_sel ? b_q[B_W-1 -: C_W] : b_q[C_W-1:0];

    smul_slice #(.A_W(A_W), .C_W(C_W)) u_slice (
        .clk    (clk),
        .rst    (rst),
        .a      (a_q),
        .chunk  (chunk),
        .hi_sel (hi_sel),
        .pp     (pp)
    );

    smul_accum #(.PP_W(PP_W), .P_W(P_W), .SH(C_W)) u_accum (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .pp    (pp),
        .prod  (product)
    );

    // R3
    operands_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> ($stable(a_q) && $stable(b_q)));

    // R6
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!done && (product == '0)));

    // R4
    done_after_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HI) |=> done);

endmodule

// File: tb/smul_ts_top_tb.sv
module smul_ts_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [16:0] a_in = '0;
    logic [13:0] b_in = '0;
    logic        done;
    logic [30:0] product;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    smul_ts_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .a_in    (a_in),
        .b_in    (b_in),
        .done    (done),
        .product (product)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sprod(input logic [30:0] p);
        return longint'($signed(p));
    endfunction

    // One full operation; checks R1/R2 value, R3 capture and R4 timing
    task automatic run_op(input logic [16:0] a, input logic [13:0] b, input bit timing);
        longint exp;
        string  req;
        exp = longint'($signed(a)) * longint'($signed(b));
        req = b[6] ? "R2" : "R1";
        a_in  = a;
        b_in  = b;
        start = 1'b1;
        @(posedge clk); #1;              // E0 accepted
        start = 1'b0;
        a_in  = ~a;                      // R3: later changes must not matter
        b_in  = b ^ 14'h2AB5;
        @(posedge clk); #1;              // E1
        if (timing) chk(done == 1'b0, "R4", longint'(done), 0);
        @(posedge clk); #1;              // E2
        if (timing) chk(done == 1'b1, "R4", longint'(done), 1);
        chk(sprod(product) == exp, req, sprod(product), exp);
        @(posedge clk); #1;              // E3
        if (timing) chk(done == 1'b0, "R4", longint'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        longint held;
        // R6: reset state
        repeat (2) @(posedge clk); #1;
        chk(done == 1'b0, "R6", longint'(done), 0);
        chk(product == '0, "R6", sprod(product), 0);
        rst = 1'b0;
        @(posedge clk); #1;

        // R2: bit 6 of the multiplier has positive weight
        run_op(17'd1, 14'd64, 1'b1);
        run_op(17'd1, 14'd127, 1'b1);
        run_op(17'h1FFFF, 14'd64, 1'b1);
        // R1 corners
        run_op(17'h10000, 14'h2000, 1'b1);
        run_op(17'h10000, 14'h1FFF, 1'b1);
        run_op(17'h0FFFF, 14'h2000, 1'b1);
        run_op(17'd0, 14'h2000, 1'b1);
        run_op(17'h10000, 14'd0, 1'b1);
        run_op(17'h0FFFF, 14'h1FFF, 1'b1);

        // R1/R2: exhaustive multiplier with the most negative multiplicand
        for (int b = 0; b < 16384; b++) run_op(17'h10000, 14'(b), 1'b0);

        // R1: multiplicand sweep against fixed multipliers
        for (int k = 0; k < 5; k++) begin
            logic [13:0] bv;
            case (k)
                0: bv = 14'h2000;
                1: bv = 14'd64;
                2: bv = 14'd127;
                3: bv = 14'h1FFF;
                default: bv = 14'h3FFF;
            endcase
            for (int a = 0; a < 131072; a += 97) run_op(17'(a), bv, 1'b0);
        end

        // R1: pseudo-random pairs
        for (int n = 0; n < 1000; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            run_op(seed[30:14], seed[13:0], (n % 50) == 0);
        end

        // R5: start held high during busy cycles
        a_in = 17'd300; b_in = 14'd77; start = 1'b1;
        @(posedge clk); #1;              // E0 accepted
        a_in = 17'd5; b_in = 14'd5;      // start still high at E1, E2
        @(posedge clk); #1;
        @(posedge clk); #1;              // E2
        start = 1'b0;
        chk(done == 1'b1, "R5", longint'(done), 1);
        chk(sprod(product) == 23100, "R5", sprod(product), 23100);
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(done == 1'b0, "R5", longint'(done), 0);
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(done == 1'b0, "R5", longint'(done), 0);
        chk(sprod(product) == 23100, "R5", sprod(product), 23100);

        // R7: result held over idle cycles
        held = sprod(product);
        repeat (6) @(posedge clk); #1;
        chk(sprod(product) == held, "R7", sprod(product), held);

        // R6: reset in the middle of an operation
        a_in = 17'd1000; b_in = 14'd1000; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        rst = 1'b1;
        @(posedge clk); #1;
        chk(done == 1'b0, "R6", longint'(done), 0);
        chk(product == '0, "R6", sprod(product), 0);
        rst = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk(done == 1'b0, "R6", longint'(done), 0);
        chk(product == '0, "R6", sprod(product), 0);
        run_op(17'h1FFFF, 14'h3FFF, 1'b1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule